// File: doc/BRIEF.md
# Programmable Interval Timer with Vectored Interrupt Request

A per-CPU periodic timer on a simple register bus. Software writes a reload count in bus clock cycles. It then sets the enable bit in the control register. From then on the timer counts bus cycles down. Each time the count expires, it reloads and raises a level interrupt request.

The request has no fixed line. It carries a vector number and a priority, both taken from fields of the control register, and an interrupt controller picks them up. A compatibility mode restricts the vector to the range 64..127 and merges the priority, shifted left by two, into the vector.

A read-only register reports the bus clock period in nanoseconds, so software can convert a time into a cycle count. The live count can also be read back.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control, reload and count registers all read 0 and `irq_req_o` is low.
- R2: Control register at offset 0x00. Bit 26 is the enable, bits 19:12 hold the 8-bit vector and bits 23:20 the 4-bit priority. All other bits are discarded on write and read back as 0.
- R3: The reload register is at 0x10. A control write with bit 26 set loads the count with max(reload,1)-1. The first request rises max(reload,1) cycles after the write edge, and the timer fires again every max(reload,1) cycles after that.
- R4: With a reload of 0 the interval is one cycle: the count stays 0 and the timer fires on every cycle.
- R5: `irq_req_o` is a level. It stays high until `irq_ack_i` is sampled high, which clears it on that edge. If an expiry falls on the same edge as the acknowledge, the request stays high.
- R6: A control write with bit 26 clear drops `irq_req_o` on that edge, freezes the count and stops all further requests.
- R7: A control write with bit 26 set while the timer runs restarts the count from the reload value.
- R8: With `compat_i` low, `irq_vec_o` equals the vector field and `irq_prio_o` equals the priority field.
- R9: With `compat_i` high, `irq_vec_o` = 0x40 | vector[5:0] | (priority << 2). `irq_prio_o` still equals the priority field.
- R10: Offset 0x14 returns the live count and offset 0x18 returns BUS_PERIOD_NS. Writes to both offsets are ignored, and unmapped offsets read 0.
- R11: A reload write while the timer runs leaves the current interval unchanged and takes effect from the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| compat_i | input | 1 | Compatibility vector mapping select |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_ack_i | input | 1 | Acknowledge, clears the request |
| irq_req_o | output | 1 | Level interrupt request |
| irq_vec_o | output | 8 | Vector presented with the request |
| irq_prio_o | output | 4 | Priority presented with the request |

## Verification
A control write lands on the one clock edge of the write task. The count reads max(reload,1)-1 at the falling edge that follows. The request rises on the max(reload,1)-th edge after the write edge. Each such check samples once one edge earlier, expecting low, and again at that edge, expecting high.

An acknowledge or a disable takes effect on its own edge, and the next falling edge shows the result. Reads are combinational and sampled in the low clock phase. The vector and priority outputs follow the control register and the mode input with no delay.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int VEC_W    = 8;
  localparam int PRIO_W   = 4;
  localparam int EN_BIT   = 26;
  localparam int VEC_LSB  = 12;
  localparam int PRIO_LSB = 20;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_BUSPD  = 8'h18;

  typedef struct packed {
    logic              en;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } ctrl_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int BUS_PERIOD_NS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o,
  output logic              stop_o
);
  logic  ctrl_wr, reload_wr;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic  wdata_unused;

  assign ctrl_wr   = bus_sel_i && bus_we_i && (bus_addr_i == OFS_CTRL);
  assign reload_wr = bus_sel_i && bus_we_i && (bus_addr_i == OFS_RELOAD);
  assign load_o    = ctrl_wr &&  bus_wdata_i[EN_BIT];
  assign stop_o    = ctrl_wr && !bus_wdata_i[EN_BIT];
  assign wdata_unused = ^bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.en   <= bus_wdata_i[EN_BIT];
        ctrl_q.prio <= bus_wdata_i[PRIO_LSB +: PRIO_W];
        ctrl_q.vec  <= bus_wdata_i[VEC_LSB +: VEC_W];
      end
      if (reload_wr) reload_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      unique case (bus_addr_i)
        OFS_CTRL: begin
          bus_rdata_o[EN_BIT]                 = ctrl_q.en;
          bus_rdata_o[PRIO_LSB +: PRIO_W]     = ctrl_q.prio;
          bus_rdata_o[VEC_LSB +: VEC_W]       = ctrl_q.vec;
        end
        OFS_RELOAD: bus_rdata_o[CNT_W-1:0] = reload_q;
        OFS_COUNT:  bus_rdata_o[CNT_W-1:0] = count_i;
        OFS_BUSPD:  bus_rdata_o            = DATA_W'(BUS_PERIOD_NS);
        default:    bus_rdata_o            = '0;
      endcase
    end
  end

  AST_CTRL_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl_q.en == $past(bus_wdata_i[EN_BIT])); // R2
  AST_RELOAD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_wr |=> $stable(reload_q)); // R11
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] count_q, start_val;

  // zero reload behaves as a one-cycle interval
  assign start_val = (reload_i == '0) ? '0 : reload_i - 1'b1;
  assign fire_o    = en_i && !load_i && (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            count_q <= '0;
    else if (load_i)        count_q <= start_val;
    else if (en_i) begin
      if (count_q == '0)    count_q <= start_val;
      else                  count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;

  AST_COUNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && count_q != '0 |=> count_q == $past(count_q) - 1'b1); // R3
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(count_q)); // R6
  AST_WRAP_ZERO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && reload_i == '0 |=> count_q == '0); // R4
endmodule

// File: rtl/pit_irq_gen.sv
module pit_irq_gen
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              compat_i,
  input  ctrl_t             ctrl_i,
  input  logic              fire_i,
  input  logic              stop_i,
  input  logic              ack_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [PRIO_W-1:0] irq_prio_o
);
  localparam int LOW_W = VEC_W - 2;
  logic irq_q;
  logic [VEC_W-1:0] vec_compat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (stop_i)  irq_q <= 1'b0;
    else if (fire_i)  irq_q <= 1'b1;  // expiry wins over acknowledge
    else if (ack_i)   irq_q <= 1'b0;
  end

  // upper two vector bits forced to 01, priority merged above bit 1
  assign vec_compat = {2'b01, ctrl_i.vec[LOW_W-1:0]}
                    | (VEC_W'(ctrl_i.prio) << 2);

  assign irq_req_o  = irq_q;
  assign irq_vec_o  = compat_i ? vec_compat : ctrl_i.vec;
  assign irq_prio_o = ctrl_i.prio;

  AST_IRQ_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en |-> !irq_q); // R6
  AST_IRQ_LEVEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !ack_i && !stop_i |=> irq_q); // R5
  AST_FIRE_BEATS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !stop_i |=> irq_q); // R5
  AST_COMPAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compat_i |-> irq_vec_o[VEC_W-1 -: 2] == 2'b01); // R9
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int BUS_PERIOD_NS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              compat_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              irq_ack_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [PRIO_W-1:0] irq_prio_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, count;
  logic             load, stop, fire;

  pit_regs #(.CNT_W(CNT_W), .BUS_PERIOD_NS(BUS_PERIOD_NS)) u_regs (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .count_i(count), .ctrl_o(ctrl), .reload_o(reload),
    .load_o(load), .stop_o(stop)
  );

  pit_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni, .en_i(ctrl.en), .load_i(load), .reload_i(reload),
    .count_o(count), .fire_o(fire)
  );

  pit_irq_gen u_irq (
    .clk_i, .rst_ni, .compat_i, .ctrl_i(ctrl), .fire_i(fire), .stop_i(stop),
    .ack_i(irq_ack_i), .irq_req_o, .irq_vec_o, .irq_prio_o
  );
endmodule

// File: tb/test_pit_timer.sv
module test_pit_timer;
  localparam int PD = 8;
  localparam logic [31:0] EN = 32'h0400_0000;

  logic        clk = 1'b0, rst_ni = 1'b0, compat = 1'b0;
  logic        sel = 1'b0, we = 1'b0, ack = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  logic [7:0]  vec;
  logic [3:0]  prio;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pit_timer #(.CNT_W(32), .BUS_PERIOD_NS(PD)) i_pit_timer (
    .clk_i(clk), .rst_ni, .compat_i(compat), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_ack_i(ack), .irq_req_o(irq), .irq_vec_o(vec), .irq_prio_o(prio)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; consumes exactly one rising edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h10, d); chk("R1 reload", d, 0);
    rd(8'h14, d); chk("R1 count", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(8'h00, 32'hFBFF_FFFF);
    rd(8'h00, d); chk("R2 masked readback", d, 32'h00FF_F000);
    compat = 1'b1; #1 chk("R9 vec all ones", vec, 8'h7F);
    wr(8'h00, 32'h0038_5000);
    compat = 1'b0; #1;
    chk("R8 vec", vec, 8'h85); chk("R8 prio", prio, 4'h3);
    compat = 1'b1; #1;
    chk("R9 vec", vec, 8'h4D); chk("R9 prio", prio, 4'h3);
    compat = 1'b0;
    chk("R2 disabled no irq", irq, 0);
  endtask

  task automatic t_period();
    logic [31:0] d;
    wr(8'h10, 5);
    wr(8'h00, EN | 32'h0038_5000);
    rd(8'h14, d); chk("R3 count after load", d, 4);
    cyc(4); chk("R3 before first expiry", irq, 0);
    cyc(1); chk("R3 first expiry", irq, 1);
    cyc(6); chk("R5 level held", irq, 1);
    // re-align: disable and restart to test ack against period
    wr(8'h00, 0);
    wr(8'h00, EN);
    cyc(4); cyc(1); chk("R3 expiry again", irq, 1);
    pulse_ack(); chk("R5 ack clears", irq, 0);
    cyc(3); chk("R3 no early second expiry", irq, 0);
    cyc(1); chk("R3 second expiry", irq, 1);
    wr(8'h00, 0);
  endtask

  task automatic t_zero_reload();
    logic [31:0] d;
    wr(8'h10, 0);
    wr(8'h00, EN);
    rd(8'h14, d); chk("R4 count zero", d, 0);
    chk("R4 not yet", irq, 0);
    cyc(1); chk("R4 fires after one cycle", irq, 1);
    ack = 1'b1; cyc(4); chk("R5 expiry beats ack", irq, 1);
    ack = 1'b0;
    rd(8'h14, d); chk("R4 count stays zero", d, 0);
    wr(8'h00, 0);
  endtask

  task automatic t_stop();
    logic [31:0] a, b;
    wr(8'h10, 3);
    wr(8'h00, EN);
    cyc(3); chk("R3 reload 3 expiry", irq, 1);
    wr(8'h00, 0); chk("R6 disable drops irq", irq, 0);
    rd(8'h14, a);
    cyc(6);
    rd(8'h14, b); chk("R6 count frozen", b, a);
    chk("R6 no further request", irq, 0);
    wr(8'h14, 32'h55);
    rd(8'h14, b); chk("R10 count write ignored", b, a);
    wr(8'h18, 32'h77);
    rd(8'h18, b); chk("R10 bus period", b, PD);
    rd(8'h04, b); chk("R10 unmapped", b, 0);
    rd(8'h10, b); chk("R3 reload readback", b, 3);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    wr(8'h10, 8);
    wr(8'h00, EN);
    cyc(3);
    rd(8'h14, d); chk("R7 count running", d, 4);
    wr(8'h00, EN);
    rd(8'h14, d); chk("R7 restarted", d, 7);
    cyc(7); chk("R7 no expiry before full interval", irq, 0);
    cyc(1); chk("R7 expiry after restart", irq, 1);
    wr(8'h00, 0);
  endtask

  task automatic t_reload_change();
    logic [31:0] d;
    wr(8'h10, 6);
    wr(8'h00, EN);
    wr(8'h10, 3);
    rd(8'h14, d); chk("R11 count not reloaded", d, 4);
    cyc(4); chk("R11 old interval kept", irq, 0);
    cyc(1); chk("R11 first expiry at old interval", irq, 1);
    pulse_ack(); chk("R5 ack", irq, 0);
    cyc(1); chk("R11 new interval not early", irq, 0);
    cyc(1); chk("R11 new interval", irq, 1);
    wr(8'h00, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_fields();
    wr(8'h00, 0);
    t_period();
    t_zero_reload();
    t_stop();
    t_restart();
    t_reload_change();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule